// File: doc/BRIEF.md
# Page Write Buffer and Word Address Counter

This block sits behind the bit-level front end of a two-wire serial memory. It keeps the 11-bit internal word address and a 16-byte staging buffer for page writes. It also holds a 2048 x 8 storage array model. The front end delivers decoded events, one per clock at most:
- a set-address event, carrying the full 11-bit location (3 bits taken from the slave address byte joined to 8 bits from the word address byte);
- a write-byte event with its data;
- a read-advance event, issued after each byte sent to the master;
- a stop event that closes a write transaction.

Written bytes collect in the staging buffer. Each buffered byte has its own valid flag. The stop event starts a self-timed commit. The commit copies only the flagged bytes into the array, then holds a busy flag for a fixed number of system clocks. While busy is high, all new address, write and read events are refused, so the front end can withhold its acknowledge, and a master can poll until the block answers again. The current address and the array byte stored at that address are always available to the front end, which uses them for current-address and sequential reads.

Top module: `pwb_engine`

## Requirements
- R1: A set-address event loads its 11-bit value, and `rdAddr` shows that value from the next cycle on.
- R2: A write-byte event increments only address bits [3:0], which wrap from 15 to 0. Bits [10:4] stay unchanged. The address after the last written byte is one past that byte within its 16-byte page.
- R3: When more than 16 bytes are written in one transaction, the later bytes overwrite the earlier ones at the same page offsets. After the commit, each offset holds the last byte written to it.
- R4: A read-advance event increments all 11 address bits, and the address wraps from 2047 to 0.
- R5: A stop event with at least one buffered byte raises `busy` on the next cycle. `busy` then stays high for exactly BUSY_CYCLES cycles.
- R6: A commit writes only the page offsets written in that transaction. All other bytes of the page keep their earlier contents.
- R7: A stop event with no buffered byte (for example, after a set-address-only dummy write) commits nothing and leaves `busy` low.
- R8: While `busy` is high, set-address, write-byte, read-advance and stop events have no effect on `rdAddr` or on the array.
- R9: A set-address event discards any bytes buffered but not yet committed.
- R10: `rdData` shows the array byte at `rdAddr` in the same cycle. After a commit, it returns the committed data.
- R11: After reset, `busy` is 0 and `rdAddr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| setAddrEvt | input | 1 | Load the word address |
| setAddrValue | input | 11 | Address to load |
| wrByteEvt | input | 1 | Stage one data byte |
| wrByteData | input | 8 | Data byte to stage |
| rdAdvEvt | input | 1 | Step the address after a read byte |
| stopEvt | input | 1 | Stop that closes a write transaction |
| busy | output | 1 | Commit in progress; events refused |
| rdAddr | output | 11 | Current word address |
| rdData | output | 8 | Array byte at the current address |

## Verification
If the address register is wrong, `rdAddr` shows the error one cycle after the event that caused it, so the bench compares the address after every event. If the valid flags or the staging buffer are wrong, the error stays hidden until the commit ends. It then shows as wrong bytes when the page is read back. For this reason, the bench re-reads whole pages after full, partial and overflowing writes. If the busy timer is wrong, the busy window has the wrong length, or events that should have been refused change the address during the window.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  localparam int PAGE_BITS  = 4;
  localparam int PAGE_BYTES = 1 << PAGE_BITS;

  typedef struct packed {
    logic                 loadAddr;
    logic                 writeByte;
    logic                 advance;
    logic                 commitEn;
    logic [PAGE_BITS-1:0] commitIdx;
    logic                 clearMask;
  } pwbStrobe_t;
endpackage

// File: rtl/pwb_ctrl.sv
module pwb_ctrl
  import pwb_pkg::*;
#(
  parameter int BUSY_CYCLES = 40
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       setAddrEvt,
  input  logic       wrByteEvt,
  input  logic       rdAdvEvt,
  input  logic       stopEvt,
  input  logic       anyPending,
  output pwbStrobe_t strobe,
  output logic       busy
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BUSY_CYCLES - 1);
  localparam logic [CNT_W-1:0] PAGE_END = CNT_W'(PAGE_BYTES);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == LAST) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (stopEvt && anyPending) begin
      busy <= 1'b1;
      cnt  <= '0;
    end
  end

  always_comb begin
    strobe.loadAddr  = setAddrEvt & ~busy;
    strobe.writeByte = wrByteEvt & ~busy & ~setAddrEvt;
    strobe.advance   = rdAdvEvt & ~busy & ~setAddrEvt & ~wrByteEvt;
    strobe.commitEn  = busy && (cnt < PAGE_END);
    strobe.commitIdx = cnt[PAGE_BITS-1:0];
    strobe.clearMask = busy && (cnt == LAST);
  end

  // R5: busy only rises after an accepted stop
  p_busy_start_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(stopEvt));
  // R7: a stop with nothing staged leaves the block idle
  p_no_empty_commit_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stopEvt && !busy && !anyPending) |=> !busy);
endmodule

// File: rtl/pwb_datapath.sv
module pwb_datapath
  import pwb_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  pwbStrobe_t        strobe,
  input  logic [ADDR_W-1:0] setAddrValue,
  input  logic [DATA_W-1:0] wrByteData,
  output logic              anyPending,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int HI_W  = ADDR_W - PAGE_BITS;

  logic [ADDR_W-1:0]    addr;
  logic [PAGE_BYTES-1:0] mask;
  logic [DATA_W-1:0]    stage [PAGE_BYTES];
  logic [DATA_W-1:0]    mem   [DEPTH];

  wire [HI_W-1:0]      pageBase = addr[ADDR_W-1:PAGE_BITS];
  wire [PAGE_BITS-1:0] offset   = addr[PAGE_BITS-1:0];

  always_ff @(posedge clk) begin
    if (!rstN)                 addr <= '0;
    else if (strobe.loadAddr)  addr <= setAddrValue;
    else if (strobe.writeByte) addr <= {pageBase, offset + 1'b1};
    else if (strobe.advance)   addr <= addr + 1'b1;
  end

  for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_lane
    wire hit = strobe.writeByte && (offset == PAGE_BITS'(i));
    always_ff @(posedge clk) begin
      if (!rstN)                                   mask[i] <= 1'b0;
      else if (strobe.loadAddr || strobe.clearMask) mask[i] <= 1'b0;
      else if (hit)                                mask[i] <= 1'b1;
    end
    always_ff @(posedge clk) begin
      if (hit) stage[i] <= wrByteData;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.commitEn && mask[strobe.commitIdx])
      mem[{pageBase, strobe.commitIdx}] <= stage[strobe.commitIdx];
  end

  assign anyPending = |mask;
  assign rdAddr     = addr;
  assign rdData     = mem[addr];

  // R2: a staged byte moves only the in-page offset
  p_page_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.writeByte |=> (addr[ADDR_W-1:PAGE_BITS] == $past(pageBase)) &&
                         (addr[PAGE_BITS-1:0] == $past(offset) + 1'b1));
  // R4: read advance steps the full address with wrap
  p_read_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |=> addr == $past(addr) + 1'b1);
  // R9: a new address leaves nothing staged
  p_discard_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadAddr |=> !anyPending);
endmodule

// File: rtl/pwb_engine.sv
module pwb_engine
  import pwb_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int DATA_W      = 8,
  parameter int BUSY_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              setAddrEvt,
  input  logic [ADDR_W-1:0] setAddrValue,
  input  logic              wrByteEvt,
  input  logic [DATA_W-1:0] wrByteData,
  input  logic              rdAdvEvt,
  input  logic              stopEvt,
  output logic              busy,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);
  pwbStrobe_t strobe;
  logic       anyPending;

  pwb_ctrl #(.BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .setAddrEvt(setAddrEvt), .wrByteEvt(wrByteEvt),
    .rdAdvEvt(rdAdvEvt), .stopEvt(stopEvt), .anyPending(anyPending),
    .strobe(strobe), .busy(busy)
  );

  pwb_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .setAddrValue(setAddrValue),
    .wrByteData(wrByteData), .anyPending(anyPending), .rdAddr(rdAddr),
    .rdData(rdData)
  );

  // R8: the address is frozen for the whole busy window
  p_frozen_r8: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> rdAddr == $past(rdAddr));
endmodule

// File: tb/pwb_engine_test.sv
module pwb_engine_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rstN, setAddrEvt, wrByteEvt, rdAdvEvt, stopEvt;
  logic [10:0] setAddrValue;
  logic [7:0]  wrByteData;
  logic        busy;
  logic [10:0] rdAddr;
  logic [7:0]  rdData;

  pwb_engine uut (
    .clk(clk), .rstN(rstN), .setAddrEvt(setAddrEvt), .setAddrValue(setAddrValue),
    .wrByteEvt(wrByteEvt), .wrByteData(wrByteData), .rdAdvEvt(rdAdvEvt),
    .stopEvt(stopEvt), .busy(busy), .rdAddr(rdAddr), .rdData(rdData)
  );

  int nChk = 0, nBad = 0;
  localparam int BUSY_LEN = 40;
  localparam int OP_SET = 0, OP_WR = 1, OP_ADV = 2, OP_STOP = 3;

  // {op[1:0], arg[10:0], expected rdAddr[10:0]}
  localparam logic [23:0] VEC [10] = '{
    {2'd0, 11'h7FE, 11'h7FE},   // R1
    {2'd2, 11'h000, 11'h7FF},   // R4
    {2'd2, 11'h000, 11'h000},   // R4 wrap
    {2'd0, 11'h13D, 11'h13D},   // R1
    {2'd1, 11'h0A1, 11'h13E},   // R2
    {2'd1, 11'h0A2, 11'h13F},   // R2
    {2'd1, 11'h0A3, 11'h130},   // R2 page wrap
    {2'd2, 11'h000, 11'h131},   // R4
    {2'd0, 11'h555, 11'h555},   // R1, R9 discard
    {2'd2, 11'h000, 11'h556}    // R4
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic evt(input int op, input logic [10:0] v);
    @(negedge clk);
    setAddrEvt = (op == OP_SET);
    wrByteEvt  = (op == OP_WR);
    rdAdvEvt   = (op == OP_ADV);
    stopEvt    = (op == OP_STOP);
    setAddrValue = v;
    wrByteData   = v[7:0];
    @(negedge clk);
    setAddrEvt = 0; wrByteEvt = 0; rdAdvEvt = 0; stopEvt = 0;
  endtask

  task automatic waitIdle(output int len);
    len = 0;
    while (busy && len < 1000) begin
      len++;
      @(negedge clk);
    end
  endtask

  task automatic readPage(input logic [10:0] base, input logic [7:0] exp [16], input string req);
    evt(OP_SET, base);
    for (int i = 0; i < 16; i++) begin
      chk(rdData === exp[i], req, rdData, exp[i]);
      evt(OP_ADV, 11'h0);
    end
  endtask

  initial begin
    #(8 * 150000);
    nBad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    logic [7:0] page [16];
    int len;
    rstN = 0; setAddrEvt = 0; wrByteEvt = 0; rdAdvEvt = 0; stopEvt = 0;
    setAddrValue = '0; wrByteData = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(busy === 1'b0, "R11 busy", busy, 0);
    chk(rdAddr === 11'h0, "R11 addr", rdAddr, 0);

    for (int k = 0; k < 10; k++) begin
      evt(int'(VEC[k][23:22]), VEC[k][21:11]);
      chk(rdAddr === VEC[k][10:0], "R1/R2/R4 vector", rdAddr, VEC[k][10:0]);
    end

    // Full page write, busy length R5
    evt(OP_SET, 11'h240);
    for (int i = 0; i < 16; i++) evt(OP_WR, 11'(8'h10 + i));
    chk(rdAddr === 11'h240, "R2 offset wrap after 16", rdAddr, 11'h240);
    evt(OP_STOP, 11'h0);
    chk(busy === 1'b1, "R5 busy rise", busy, 1);
    waitIdle(len);
    chk(len == BUSY_LEN, "R5 busy length", len, BUSY_LEN);
    for (int i = 0; i < 16; i++) page[i] = 8'(8'h10 + i);
    readPage(11'h240, page, "R10 full page readback");

    // Partial write R6
    evt(OP_SET, 11'h243);
    evt(OP_WR, 11'h0EE);
    evt(OP_WR, 11'h0EF);
    chk(rdAddr === 11'h245, "R2 next address", rdAddr, 11'h245);
    evt(OP_STOP, 11'h0);
    waitIdle(len);
    page[3] = 8'hEE; page[4] = 8'hEF;
    readPage(11'h240, page, "R6 partial commit");

    // Overflow R3: 18 bytes from offset 14
    evt(OP_SET, 11'h31E);
    for (int k = 0; k < 18; k++) evt(OP_WR, 11'(8'h40 + k));
    evt(OP_STOP, 11'h0);
    waitIdle(len);
    for (int o = 0; o < 16; o++) page[o] = (o < 14) ? 8'(8'h42 + o) : 8'(8'h50 + o - 14);
    readPage(11'h310, page, "R3 overflow overwrite");

    // Dummy write R7
    evt(OP_SET, 11'h100);
    evt(OP_STOP, 11'h0);
    chk(busy === 1'b0, "R7 no busy", busy, 0);
    repeat (3) @(negedge clk);
    chk(busy === 1'b0, "R7 still idle", busy, 0);
    chk(rdAddr === 11'h100, "R7 address loaded", rdAddr, 11'h100);

    // Discard R9
    evt(OP_SET, 11'h240);
    evt(OP_WR, 11'h099);
    evt(OP_SET, 11'h240);
    evt(OP_STOP, 11'h0);
    chk(busy === 1'b0, "R9 no commit", busy, 0);
    chk(rdData === 8'h10, "R9 array unchanged", rdData, 8'h10);

    // Ignored while busy R8
    evt(OP_SET, 11'h400);
    evt(OP_WR, 11'h077);
    evt(OP_STOP, 11'h0);
    evt(OP_SET, 11'h123);
    evt(OP_WR, 11'h055);
    evt(OP_ADV, 11'h0);
    chk(busy === 1'b1, "R8 still busy", busy, 1);
    chk(rdAddr === 11'h401, "R8 address frozen", rdAddr, 11'h401);
    waitIdle(len);
    chk(rdAddr === 11'h401, "R8 address after busy", rdAddr, 11'h401);
    evt(OP_SET, 11'h400);
    chk(rdData === 8'h77, "R10 committed byte", rdData, 8'h77);
    evt(OP_SET, 11'h241);
    chk(rdData === 8'h11, "R8 no write while busy", rdData, 8'h11);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule